// File: doc/BRIEF.md
# Page Translation Buffer

This block caches translations from 32-bit linear addresses to 32-bit physical addresses for 4 KB pages. All entries are compared in parallel. A lookup carries a linear address, a read/write type and a paging-enable flag. One cycle later the block returns one of three results:

- a hit with the physical address,
- a miss, which an external page-walk requester resolves by writing an entry through the fill port,
- a fault, when the matching page is marked not present.

On a fault the block stores the faulting linear address in a register that can be read at all times. A flush input empties the whole buffer.

Each entry holds three status flags: present, dirty and accessed. The first read or write that hits an entry whose accessed flag is clear is reported, and the flag is then set. The first write that hits an entry whose dirty flag is clear is reported, and that flag is then set. The requester uses these reports to write the flags back to its page tables. When paging is disabled, addresses pass through untranslated. A fill finds its slot as follows:

- a slot that already holds the same page, if there is one,
- otherwise the lowest-numbered empty slot,
- otherwise the slot named by a round-robin pointer.

Top module: `pgxlat_tlb`

## Requirements
- R1: After reset `rs_valid`, `rs_hit`, `rs_fault`, `rs_dirty_upd` and `rs_acc_upd` are 0, `fault_addr` is 0, and the buffer is empty, so every translated lookup misses.
- R2: The result of a lookup presented on `lk_valid` appears exactly one cycle later with `rs_valid`=1. In any cycle with no lookup in the previous cycle, `rs_valid`, `rs_hit`, `rs_fault`, `rs_dirty_upd` and `rs_acc_upd` are all 0.
- R3: With `lk_pg_en`=0, the result has `rs_hit`=1, `rs_phys` equal to `lk_lin`, and `rs_fault`, `rs_dirty_upd` and `rs_acc_upd` all 0. The lookup changes no entry flags.
- R4: A translated lookup that matches a present entry gives `rs_hit`=1 and `rs_phys`={stored frame, `lk_lin[11:0]`}. The page number is `lk_lin[31:12]`.
- R5: A translated lookup that matches no valid entry gives `rs_hit`=0 and `rs_fault`=0.
- R6: A translated lookup that matches an entry whose present flag is 0 gives `rs_fault`=1 and `rs_hit`=0, and loads `lk_lin` into `fault_addr` in the same cycle. `fault_addr` keeps its value at all other times. `rs_hit` and `rs_fault` are never both 1.
- R7: A write lookup that hits a present entry whose dirty flag is clear gives `rs_dirty_upd`=1 and sets the flag, so later writes to that page give 0. Read lookups never give `rs_dirty_upd`=1.
- R8: A lookup that hits a present entry whose accessed flag is clear gives `rs_acc_upd`=1 and sets the flag, so later hits give 0. A fault does not set the accessed flag.
- R9: The buffer holds 32 entries. After 32 fills of distinct pages into an empty buffer, all 32 pages hit with their own frames.
- R10: A fill into a full buffer replaces the slot named by a round-robin pointer. The pointer starts at slot 0 after reset and advances by one, wrapping, after each replacement. Fills into an empty buffer take the lowest free slot, so replacements evict pages in the order they were first filled.
- R11: A fill of a page that is already held overwrites that entry in place and does not advance the round-robin pointer.
- R12: `flush` empties every entry in one cycle, so a lookup in the next cycle misses. A fill in the same cycle as a flush is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_lin | input | 32 | Linear address to translate |
| lk_write | input | 1 | 1 = write access, 0 = read access |
| lk_pg_en | input | 1 | Paging enable; 0 passes the address through |
| fl_valid | input | 1 | Fill request from the page-walk requester |
| fl_vpn | input | 20 | Page number of the filled entry |
| fl_ppn | input | 20 | Frame number of the filled entry |
| fl_present | input | 1 | Present flag of the filled entry |
| fl_dirty | input | 1 | Dirty flag of the filled entry |
| fl_accessed | input | 1 | Accessed flag of the filled entry |
| flush | input | 1 | Empty all entries |
| rs_valid | output | 1 | Lookup result valid |
| rs_hit | output | 1 | Translation available |
| rs_fault | output | 1 | Not-present fault |
| rs_phys | output | 32 | Physical address (0 on miss or fault) |
| rs_dirty_upd | output | 1 | Write hit on a clean page; dirty flag now set |
| rs_acc_upd | output | 1 | First hit on a page; accessed flag now set |
| fault_addr | output | 32 | Linear address of the last not-present fault |

## Verification
Corrupted entry storage appears at the ports as a wrong frame in `rs_phys` or a wrong miss. This shows one cycle after the first lookup of the affected page. Flag errors show as a missing or repeated `rs_dirty_upd` or `rs_acc_upd` on the second access to a page. A wrong round-robin pointer or free-slot choice stays hidden until the buffer is full. It then shows as the wrong page missing after a replacement, so the bench fills to capacity and checks which page was evicted after each replacement and after an in-place refill. A slot selected twice would break the check that at most one entry matches, at the next lookup of that page.

// File: rtl/pgxlat_pkg.sv
package pgxlat_pkg;

   // Per-entry status flags
   typedef struct packed {
      logic present;
      logic dirty;
      logic accessed;
   } pte_flags_t;

endpackage

// File: rtl/pgxlat_store.sv
module pgxlat_store
   import pgxlat_pkg::*;
#(
   parameter int ENTRIES = 32,
   parameter int VPN_W   = 20,
   parameter int PPN_W   = 20,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [VPN_W-1:0]      lk_vpn,
   input  logic [VPN_W-1:0]      wr_vpn,
   input  logic                  wr_en,
   input  logic [IDX_W-1:0]      wr_idx,
   input  logic [PPN_W-1:0]      wr_ppn,
   input  pte_flags_t            wr_flags,
   input  logic                  upd_en,
   input  logic [IDX_W-1:0]      upd_idx,
   input  logic                  upd_dirty,
   input  logic                  flush,
   output logic [ENTRIES-1:0]    hit_vec,
   output logic [ENTRIES-1:0]    dup_vec,
   output logic [ENTRIES-1:0]    valid_vec,
   output logic [PPN_W-1:0]      ppn_arr [ENTRIES],
   output pte_flags_t            flg_arr [ENTRIES]
);

   genvar gi;
   generate
      for (gi = 0; gi < ENTRIES; gi++) begin : g_ent
         logic [VPN_W-1:0] vpn_q;
         logic [PPN_W-1:0] ppn_q;
         pte_flags_t       flg_q;
         logic             vld_q;
         logic             wr_me;
         logic             upd_me;

         assign wr_me  = wr_en  && (wr_idx  == IDX_W'(gi));
         assign upd_me = upd_en && (upd_idx == IDX_W'(gi));

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               vld_q <= 1'b0;
               vpn_q <= '0;
               ppn_q <= '0;
               flg_q <= '0;
            end else if (flush) begin
               vld_q <= 1'b0;
            end else if (wr_me) begin
               vld_q <= 1'b1;
               vpn_q <= wr_vpn;
               ppn_q <= wr_ppn;
               flg_q <= wr_flags;
            end else if (upd_me) begin
               flg_q.accessed <= 1'b1;
               flg_q.dirty    <= flg_q.dirty | upd_dirty;
            end
         end

         assign hit_vec[gi]   = vld_q && (vpn_q == lk_vpn);
         assign dup_vec[gi]   = vld_q && (vpn_q == wr_vpn);
         assign valid_vec[gi] = vld_q;
         assign ppn_arr[gi]   = ppn_q;
         assign flg_arr[gi]   = flg_q;
      end
   endgenerate

endmodule

// File: rtl/pgxlat_victim.sv
module pgxlat_victim #(
   parameter int ENTRIES = 32,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fill,
   input  logic [ENTRIES-1:0] valid_vec,
   input  logic [ENTRIES-1:0] dup_vec,
   output logic [IDX_W-1:0]   slot
);

   logic [IDX_W-1:0] rr_q;
   logic [IDX_W-1:0] dup_idx;
   logic [IDX_W-1:0] free_idx;
   logic             has_dup;
   logic             has_free;

   always_comb begin
      dup_idx  = '0;
      free_idx = '0;
      has_dup  = |dup_vec;
      has_free = ~&valid_vec;
      for (int i = 0; i < ENTRIES; i++) begin
         if (dup_vec[i]) dup_idx = dup_idx | IDX_W'(i);
      end
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (!valid_vec[i]) free_idx = IDX_W'(i);
      end
   end

   always_comb begin
      if (has_dup)       slot = dup_idx;
      else if (has_free) slot = free_idx;
      else               slot = rr_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rr_q <= '0;
      end else if (fill && !has_dup && !has_free) begin
         if (rr_q == IDX_W'(ENTRIES - 1)) rr_q <= '0;
         else                             rr_q <= rr_q + 1'b1;
      end
   end

endmodule

// File: rtl/pgxlat_tlb.sv
module pgxlat_tlb
   import pgxlat_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int OFS_W   = 12,
   parameter int ENTRIES = 32,
   localparam int VPN_W  = ADDR_W - OFS_W,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic [ADDR_W-1:0] lk_lin,
   input  logic              lk_write,
   input  logic              lk_pg_en,
   input  logic              fl_valid,
   input  logic [VPN_W-1:0]  fl_vpn,
   input  logic [VPN_W-1:0]  fl_ppn,
   input  logic              fl_present,
   input  logic              fl_dirty,
   input  logic              fl_accessed,
   input  logic              flush,
   output logic              rs_valid,
   output logic              rs_hit,
   output logic              rs_fault,
   output logic [ADDR_W-1:0] rs_phys,
   output logic              rs_dirty_upd,
   output logic              rs_acc_upd,
   output logic [ADDR_W-1:0] fault_addr
);

   generate
      if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_entries
         $error("ENTRIES must be a power of two of at least 2");
      end
      if (OFS_W < 1 || OFS_W >= ADDR_W) begin : g_bad_ofs
         $error("OFS_W must lie between 1 and ADDR_W-1");
      end
   endgenerate

   logic [VPN_W-1:0]   lk_vpn;
   logic [ENTRIES-1:0] hit_vec;
   logic [ENTRIES-1:0] dup_vec;
   logic [ENTRIES-1:0] valid_vec;
   logic [VPN_W-1:0]   ppn_arr [ENTRIES];
   pte_flags_t         flg_arr [ENTRIES];
   logic [IDX_W-1:0]   fill_slot;
   logic               fill_go;
   logic [VPN_W-1:0]   sel_ppn;
   pte_flags_t         sel_flg;
   logic [IDX_W-1:0]   sel_idx;
   logic               any_hit;
   logic               xl_req;
   logic               ok_hit;
   logic               bad_page;
   logic               upd_en;
   pte_flags_t         fl_flags;

   assign lk_vpn   = lk_lin[ADDR_W-1:OFS_W];
   assign fill_go  = fl_valid && !flush;
   assign fl_flags = '{present: fl_present, dirty: fl_dirty, accessed: fl_accessed};

   pgxlat_store #(
      .ENTRIES (ENTRIES),
      .VPN_W   (VPN_W),
      .PPN_W   (VPN_W)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .lk_vpn    (lk_vpn),
      .wr_vpn    (fl_vpn),
      .wr_en     (fill_go),
      .wr_idx    (fill_slot),
      .wr_ppn    (fl_ppn),
      .wr_flags  (fl_flags),
      .upd_en    (upd_en),
      .upd_idx   (sel_idx),
      .upd_dirty (lk_write),
      .flush     (flush),
      .hit_vec   (hit_vec),
      .dup_vec   (dup_vec),
      .valid_vec (valid_vec),
      .ppn_arr   (ppn_arr),
      .flg_arr   (flg_arr)
   );

   pgxlat_victim #(
      .ENTRIES (ENTRIES)
   ) u_victim (
      .clk       (clk),
      .rst_n     (rst_n),
      .fill      (fill_go),
      .valid_vec (valid_vec),
      .dup_vec   (dup_vec),
      .slot      (fill_slot)
   );

   // One-hot select of the matching entry (at most one can match)
   always_comb begin
      sel_ppn = '0;
      sel_flg = '0;
      sel_idx = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (hit_vec[i]) begin
            sel_ppn = sel_ppn | ppn_arr[i];
            sel_flg = sel_flg | flg_arr[i];
            sel_idx = sel_idx | IDX_W'(i);
         end
      end
   end

   assign any_hit  = |hit_vec;
   assign xl_req   = lk_valid && lk_pg_en;
   assign ok_hit   = xl_req && any_hit && sel_flg.present;
   assign bad_page = xl_req && any_hit && !sel_flg.present;
   assign upd_en   = ok_hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rs_valid     <= 1'b0;
         rs_hit       <= 1'b0;
         rs_fault     <= 1'b0;
         rs_phys      <= '0;
         rs_dirty_upd <= 1'b0;
         rs_acc_upd   <= 1'b0;
         fault_addr   <= '0;
      end else begin
         rs_valid     <= lk_valid;
         rs_hit       <= ok_hit || (lk_valid && !lk_pg_en);
         rs_fault     <= bad_page;
         rs_dirty_upd <= ok_hit && lk_write && !sel_flg.dirty;
         rs_acc_upd   <= ok_hit && !sel_flg.accessed;
         if (lk_valid && !lk_pg_en) rs_phys <= lk_lin;
         else if (ok_hit)           rs_phys <= {sel_ppn, lk_lin[OFS_W-1:0]};
         else                       rs_phys <= '0;
         if (bad_page) fault_addr <= lk_lin;
      end
   end

endmodule

// File: rtl/pgxlat_tlb_chk.sv
module pgxlat_tlb_chk #(
   parameter int ADDR_W  = 32,
   parameter int OFS_W   = 12,
   parameter int ENTRIES = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              lk_valid,
   input logic [ADDR_W-1:0] lk_lin,
   input logic              lk_write,
   input logic              lk_pg_en,
   input logic              flush,
   input logic              rs_valid,
   input logic              rs_hit,
   input logic              rs_fault,
   input logic [ADDR_W-1:0] rs_phys,
   input logic              rs_dirty_upd,
   input logic              rs_acc_upd,
   input logic [ADDR_W-1:0] fault_addr,
   input logic [ENTRIES-1:0] hit_vec,
   input logic [ENTRIES-1:0] valid_vec
);

   AST_RES_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> rs_valid); // R2
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> !rs_valid && !rs_hit && !rs_fault && !rs_dirty_upd && !rs_acc_upd); // R2
   AST_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid && !lk_pg_en |=> rs_hit && !rs_fault && rs_phys == $past(lk_lin)); // R3
   AST_OFS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> (!rs_hit || rs_phys[OFS_W-1:0] == $past(lk_lin[OFS_W-1:0]))); // R4
   AST_HIT_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(rs_hit && rs_fault)); // R6
   AST_FAULT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> (!rs_fault || fault_addr == $past(lk_lin))); // R6
   AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rs_fault |-> $stable(fault_addr)); // R6
   AST_READ_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid && !lk_write |=> !rs_dirty_upd); // R7
   AST_ACC_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (rs_acc_upd || rs_dirty_upd) |-> rs_hit); // R8
   AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec)); // R11
   AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> valid_vec == '0); // R12

endmodule

bind pgxlat_tlb pgxlat_tlb_chk #(
   .ADDR_W  (ADDR_W),
   .OFS_W   (OFS_W),
   .ENTRIES (ENTRIES)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .lk_valid     (lk_valid),
   .lk_lin       (lk_lin),
   .lk_write     (lk_write),
   .lk_pg_en     (lk_pg_en),
   .flush        (flush),
   .rs_valid     (rs_valid),
   .rs_hit       (rs_hit),
   .rs_fault     (rs_fault),
   .rs_phys      (rs_phys),
   .rs_dirty_upd (rs_dirty_upd),
   .rs_acc_upd   (rs_acc_upd),
   .fault_addr   (fault_addr),
   .hit_vec      (hit_vec),
   .valid_vec    (valid_vec)
);

// File: tb/pgxlat_tlb_bench.sv
module pgxlat_tlb_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_valid = 1'b0;
   logic [31:0] lk_lin = '0;
   logic        lk_write = 1'b0;
   logic        lk_pg_en = 1'b0;
   logic        fl_valid = 1'b0;
   logic [19:0] fl_vpn = '0;
   logic [19:0] fl_ppn = '0;
   logic        fl_present = 1'b0;
   logic        fl_dirty = 1'b0;
   logic        fl_accessed = 1'b0;
   logic        flush = 1'b0;
   logic        rs_valid, rs_hit, rs_fault, rs_dirty_upd, rs_acc_upd;
   logic [31:0] rs_phys, fault_addr;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   pgxlat_tlb u_pgxlat_tlb (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_valid), .lk_lin(lk_lin), .lk_write(lk_write), .lk_pg_en(lk_pg_en),
      .fl_valid(fl_valid), .fl_vpn(fl_vpn), .fl_ppn(fl_ppn),
      .fl_present(fl_present), .fl_dirty(fl_dirty), .fl_accessed(fl_accessed),
      .flush(flush),
      .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_fault(rs_fault), .rs_phys(rs_phys),
      .rs_dirty_upd(rs_dirty_upd), .rs_acc_upd(rs_acc_upd), .fault_addr(fault_addr)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Lookup: drive for one cycle, sample the registered result at the next negedge
   task automatic lookup(input logic [31:0] lin, input logic wr, input logic pg);
      @(negedge clk);
      lk_valid = 1'b1; lk_lin = lin; lk_write = wr; lk_pg_en = pg;
      @(negedge clk);
      lk_valid = 1'b0; lk_write = 1'b0;
   endtask

   task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn,
                       input logic p, input logic d, input logic a, input logic with_flush);
      @(negedge clk);
      fl_valid = 1'b1; fl_vpn = vpn; fl_ppn = ppn;
      fl_present = p; fl_dirty = d; fl_accessed = a; flush = with_flush;
      @(negedge clk);
      fl_valid = 1'b0; flush = 1'b0;
   endtask

   task automatic do_flush();
      @(negedge clk);
      flush = 1'b1;
      @(negedge clk);
      flush = 1'b0;
   endtask

   task automatic expect_hit(input string tag, input logic [31:0] lin, input logic [19:0] ppn);
      lookup(lin, 1'b0, 1'b1);
      check({tag, " hit"}, {31'd0, rs_hit}, 32'd1);
      check({tag, " phys"}, rs_phys, {ppn, lin[11:0]});
   endtask

   task automatic expect_miss(input string tag, input logic [31:0] lin);
      lookup(lin, 1'b0, 1'b1);
      check({tag, " hit"}, {31'd0, rs_hit}, 32'd0);
      check({tag, " fault"}, {31'd0, rs_fault}, 32'd0);
   endtask

   task automatic t_reset();
      check("R1 rs_valid", {31'd0, rs_valid}, 32'd0);
      check("R1 rs_hit", {31'd0, rs_hit}, 32'd0);
      check("R1 fault_addr", fault_addr, 32'd0);
      expect_miss("R1 empty", 32'h1234_5678);
   endtask

   task automatic t_latency();
      lookup(32'h0000_1000, 1'b0, 1'b0);
      check("R2 rs_valid after request", {31'd0, rs_valid}, 32'd1);
      @(negedge clk);
      check("R2 rs_valid idle", {31'd0, rs_valid}, 32'd0);
      check("R2 rs_hit idle", {31'd0, rs_hit}, 32'd0);
   endtask

   task automatic t_passthru();
      lookup(32'hDEAD_BEEF, 1'b1, 1'b0);
      check("R3 hit", {31'd0, rs_hit}, 32'd1);
      check("R3 phys", rs_phys, 32'hDEAD_BEEF);
      check("R3 dirty_upd", {31'd0, rs_dirty_upd}, 32'd0);
      check("R3 acc_upd", {31'd0, rs_acc_upd}, 32'd0);
   endtask

   task automatic t_flags();
      fill(20'h12345, 20'hABCDE, 1'b1, 1'b0, 1'b0, 1'b0);
      // A pass-through write to the same address must leave the flags alone
      lookup(32'h1234_5678, 1'b1, 1'b0);
      lookup(32'h1234_5678, 1'b0, 1'b1);
      check("R4 hit", {31'd0, rs_hit}, 32'd1);
      check("R4 phys", rs_phys, 32'hABCD_E678);
      check("R8 first acc_upd", {31'd0, rs_acc_upd}, 32'd1);
      check("R7 read no dirty_upd", {31'd0, rs_dirty_upd}, 32'd0);
      lookup(32'h1234_5ABC, 1'b0, 1'b1);
      check("R8 second acc_upd", {31'd0, rs_acc_upd}, 32'd0);
      lookup(32'h1234_5004, 1'b1, 1'b1);
      check("R7 first write dirty_upd", {31'd0, rs_dirty_upd}, 32'd1);
      lookup(32'h1234_5008, 1'b1, 1'b1);
      check("R7 second write dirty_upd", {31'd0, rs_dirty_upd}, 32'd0);
      expect_miss("R5 other page", 32'h1234_6000);
   endtask

   task automatic t_fault();
      fill(20'h00777, 20'h55555, 1'b0, 1'b0, 1'b0, 1'b0);
      lookup(32'h0077_7A10, 1'b0, 1'b1);
      check("R6 fault", {31'd0, rs_fault}, 32'd1);
      check("R6 no hit", {31'd0, rs_hit}, 32'd0);
      check("R6 fault_addr", fault_addr, 32'h0077_7A10);
      lookup(32'h1234_5000, 1'b0, 1'b1);
      check("R6 fault_addr hold", fault_addr, 32'h0077_7A10);
      fill(20'h00777, 20'h55555, 1'b1, 1'b0, 1'b0, 1'b0);
      lookup(32'h0077_7000, 1'b0, 1'b1);
      check("R8 acc_upd after fault", {31'd0, rs_acc_upd}, 32'd1);
      check("R11 refill in place phys", rs_phys, 32'h5555_5000);
   endtask

   task automatic t_flush();
      do_flush();
      expect_miss("R12 after flush", 32'h1234_5000);
      fill(20'h22222, 20'h33333, 1'b1, 1'b1, 1'b1, 1'b1);
      expect_miss("R12 fill during flush dropped", 32'h2222_2000);
   endtask

   task automatic t_capacity();
      for (int i = 0; i < 32; i++)
         fill(20'h40000 + 20'(i), 20'h80000 + 20'(i), 1'b1, 1'b1, 1'b1, 1'b0);
      for (int i = 0; i < 32; i++)
         expect_hit("R9 capacity", {20'h40000 + 20'(i), 12'h010}, 20'h80000 + 20'(i));
      fill(20'h50000, 20'h60000, 1'b1, 1'b1, 1'b1, 1'b0);
      expect_miss("R10 first victim slot0", 32'h4000_0000);
      expect_hit("R10 new page", 32'h5000_0000, 20'h60000);
      expect_hit("R10 slot1 kept", 32'h4000_1000, 20'h80001);
      fill(20'h50001, 20'h60001, 1'b1, 1'b1, 1'b1, 1'b0);
      expect_miss("R10 second victim slot1", 32'h4000_1000);
      fill(20'h40005, 20'h99999, 1'b1, 1'b1, 1'b1, 1'b0);
      expect_hit("R11 overwrite", 32'h4000_5123, 20'h99999);
      fill(20'h50002, 20'h60002, 1'b1, 1'b1, 1'b1, 1'b0);
      expect_miss("R11 pointer not advanced slot2", 32'h4000_2000);
      expect_hit("R11 slot3 kept", 32'h4000_3000, 20'h80003);
      expect_hit("R10 earlier new page kept", 32'h5000_1000, 20'h60001);
   endtask

   initial begin : wd
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL R2 watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_latency();
      t_passthru();
      t_flags();
      t_fault();
      t_flush();
      t_capacity();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule